// File: doc/BRIEF.md
# Jittered PWM Timing Generator

This block sets the switching rhythm of a peak-current-mode power-switch controller. Working from one fixed system clock, it drives a gate-enable pulse train whose period is slowly swept back and forth around a nominal value. The sweep spreads the energy of each switching harmonic over nearby frequencies and so lowers conducted EMI. Each pulse starts at a period boundary. It ends in one of three ways: when a current-sense comparator trips, when the maximum duty limit is reached, or when the supervisor withdraws its enable.

Inside each pulse, two windows mask the comparator trip. A blanking window hides the turn-on spike. A trip seen after blanking but before the minimum on-time is held back until the minimum on-time has run out. Two one-clock strobes go to downstream protection logic: one marks the start of each switching cycle and one marks the end of the on-phase. A flag shows when blanking is active. A parameter selects the low-frequency variant (about 60 kHz, swept by about ±4 kHz) or the high-frequency variant (about 115 kHz, swept by about ±8 kHz). All pins are plain control levels or strobes, so there is no flow control at the edge.

Top module: `jitter_pwm_timer`

## Requirements
- R1: The switching period is measured in clocks between successive cycle-start strobes. The first cycle starts exactly one nominal period after reset is released. Each later period differs from the one before it by exactly one clock. Periods follow a triangle that rises first, turns at nominal+DEV and again at nominal−DEV, and repeats. With a 50 MHz clock the high variant has nominal 434 and DEV 30, and the low variant has 833 and 55.
- R2: With no trip, the gate stays high for exactly MAXON clocks, where MAXON is nominal×70/100 (303 for the high variant, 583 for the low variant at 50 MHz).
- R3: A trip sampled in the first BLANK clocks of a pulse (15 at 50 MHz, phases 0..14) has no effect. blank_o is high exactly in those clocks while the gate is high.
- R4: A trip sampled at phase BLANK or later but before phase MINON−1 (MINON is 24 at 50 MHz) ends the pulse after exactly MINON clocks.
- R5: A trip sampled at phase t, where MINON−1 ≤ t < MAXON, ends the pulse after t+1 clocks. The gate then stays low for the rest of the cycle.
- R6: When run_en_i falls, gate_o goes low in the same clock. A new pulse begins only at a period boundary at which run_en_i is high, so re-enabling in the middle of a period does not start a pulse.
- R7: cyc_start_o is a one-clock strobe in the first clock of each pulse.
- R8: off_o is a one-clock strobe in the clock after the last clock in which the gate was high.
- R9: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en_i | input | 1 | Enable from the supervisor; low forces the gate off |
| trip_i | input | 1 | Current-sense comparator trip, synchronous to clk |
| gate_o | output | 1 | Gate-enable to the driver |
| cyc_start_o | output | 1 | One-clock strobe at the first clock of a pulse |
| off_o | output | 1 | One-clock strobe after the gate has fallen |
| blank_o | output | 1 | High while leading-edge blanking masks the trip |

## Verification
The main function is driven for more than a full sweep of the triangle. Comparator trips are placed at chosen phases of successive cycles: inside blanking and on its last clock, on the first clock after blanking, on the clock where the minimum on-time ends, mid-pulse, on the clock before the duty limit, and as a trip held from turn-on. The mix of cases separates a wrong blanking length from a wrong minimum on-time, off-by-one limits, and a wrong sweep turn-around. Two enable drops, one short and one that spans a period boundary, show whether the gate is cut at once and whether a restart waits for the boundary.

// File: rtl/pwmj_pkg.sv
package pwmj_pkg;

  typedef enum logic {SWEEP_UP = 1'b0, SWEEP_DOWN = 1'b1} sweep_dir_e;

  // Clocks per switching period for the chosen variant.
  function automatic int unsigned nominal_period(input int unsigned clk_hz, input bit fast);
    return fast ? clk_hz / 115000 : clk_hz / 60000;
  endfunction

  // Sweep half-span in clocks, scaled from the relative frequency deviation.
  function automatic int unsigned sweep_span(input int unsigned nom, input bit fast);
    return fast ? (nom * 8) / 115 : (nom * 4) / 60;
  endfunction

  // Nanoseconds to whole clocks.
  function automatic int unsigned ns_to_clk(input int unsigned clk_hz, input int unsigned ns);
    return ((clk_hz / 1000) * ns) / 1000000;
  endfunction

endpackage

// File: rtl/pwmj_sweep.sv
module pwmj_sweep
  import pwmj_pkg::*;
#(
  parameter int unsigned NOM = 833,
  parameter int unsigned DEV = 55,
  parameter int unsigned PW  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  output logic [PW-1:0] period_o
);
  localparam int unsigned OW = $clog2(DEV + 1) + 1;
  localparam logic signed [OW-1:0] TOP = OW'(DEV);
  localparam logic signed [OW-1:0] BOT = -TOP;
  localparam logic signed [OW-1:0] ONE = OW'(1);

  logic signed [OW-1:0] ofs_q;
  sweep_dir_e           dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q <= '0;
      dir_q <= SWEEP_UP;
    end else if (step_i) begin
      if (dir_q == SWEEP_UP) begin
        if (ofs_q >= TOP) begin
          dir_q <= SWEEP_DOWN;
          ofs_q <= ofs_q - ONE;
        end else begin
          ofs_q <= ofs_q + ONE;
        end
      end else begin
        if (ofs_q <= BOT) begin
          dir_q <= SWEEP_UP;
          ofs_q <= ofs_q + ONE;
        end else begin
          ofs_q <= ofs_q - ONE;
        end
      end
    end
  end

  assign period_o = PW'(NOM) + PW'(ofs_q);

  assert_sweep_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_q <= TOP) && (ofs_q >= BOT));
  assert_sweep_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step_i) |-> (ofs_q != $past(ofs_q)));
  assert_sweep_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step_i) |-> $stable(ofs_q));

endmodule

// File: rtl/pwmj_phase.sv
module pwmj_phase #(
  parameter int unsigned NOM = 833,
  parameter int unsigned PW  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] next_per_i,
  output logic [PW-1:0] phase_o,
  output logic          wrap_o
);
  logic [PW-1:0] per_q;
  logic [PW-1:0] phase_q;

  assign wrap_o  = (phase_q == per_q - PW'(1));
  assign phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q   <= PW'(NOM);
      phase_q <= '0;
    end else if (wrap_o) begin
      per_q   <= next_per_i;
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PW'(1);
    end
  end

  assert_phase_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < per_q);
  assert_period_only_at_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrap_o) |-> $stable(per_q));

endmodule

// File: rtl/pwmj_gate.sv
module pwmj_gate #(
  parameter int unsigned PW    = 10,
  parameter int unsigned MAXON = 583,
  parameter int unsigned BLANK = 15,
  parameter int unsigned MINON = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          trip_i,
  input  logic [PW-1:0] phase_i,
  input  logic          wrap_i,
  output logic          gate_o,
  output logic          start_o,
  output logic          off_o,
  output logic          blank_o
);
  localparam logic [PW-1:0] BLANK_L = PW'(BLANK);
  localparam logic [PW-1:0] MINL_L  = PW'(MINON - 1);
  localparam logic [PW-1:0] MAXL_L  = PW'(MAXON - 1);
  localparam logic [PW-1:0] MAX_L   = PW'(MAXON);

  logic gate_q, pend_q, prev_q;
  logic in_blank, trip_live, trip_any, min_met, hit_max;

  assign in_blank  = phase_i < BLANK_L;
  assign trip_live = trip_i && !in_blank;
  assign trip_any  = trip_live || pend_q;
  assign min_met   = phase_i >= MINL_L;
  assign hit_max   = phase_i >= MAXL_L;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= gate_q;
      if (wrap_i) begin
        gate_q <= en_i;
        pend_q <= 1'b0;
      end else if (!en_i) begin
        gate_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (gate_q) begin
        if (hit_max || (trip_any && min_met)) begin
          gate_q <= 1'b0;
          pend_q <= 1'b0;
        end else if (trip_live) begin
          pend_q <= 1'b1;
        end
      end
    end
  end

  assign gate_o  = gate_q && en_i;
  assign start_o = gate_o && (phase_i == '0);
  assign off_o   = prev_q && !gate_q;
  assign blank_o = gate_o && in_blank;

  assert_max_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> (phase_i < MAX_L));
  assert_blank_no_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i <= BLANK_L) |-> !pend_q);
  assert_min_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_q) && $past(en_i)) |-> ($past(phase_i) >= MINL_L));
  assert_rise_on_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> ((phase_i == '0) && $past(en_i)));
  assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> !gate_q);
  assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  assert_off_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    off_o |=> !off_o);

endmodule

// File: rtl/jitter_pwm_timer.sv
module jitter_pwm_timer
  import pwmj_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 50000000,
  parameter bit          FAST_VARIANT = 1'b0,
  parameter int unsigned DUTY_PCT     = 70,
  parameter int unsigned BLANK_NS     = 300,
  parameter int unsigned MIN_ON_NS    = 480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en_i,
  input  logic trip_i,
  output logic gate_o,
  output logic cyc_start_o,
  output logic off_o,
  output logic blank_o
);
  localparam int unsigned NOM   = nominal_period(CLK_HZ, FAST_VARIANT);
  localparam int unsigned DEV   = sweep_span(NOM, FAST_VARIANT);
  localparam int unsigned MAXON = (NOM * DUTY_PCT) / 100;
  localparam int unsigned BLANK = ns_to_clk(CLK_HZ, BLANK_NS);
  localparam int unsigned MINON = ns_to_clk(CLK_HZ, MIN_ON_NS);
  localparam int unsigned PW    = $clog2(NOM + DEV + 1);

  logic [PW-1:0] next_per;
  logic [PW-1:0] phase;
  logic          wrap;

  pwmj_sweep #(.NOM(NOM), .DEV(DEV), .PW(PW)) u_sweep (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (wrap),
    .period_o (next_per)
  );

  pwmj_phase #(.NOM(NOM), .PW(PW)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .next_per_i (next_per),
    .phase_o    (phase),
    .wrap_o     (wrap)
  );

  pwmj_gate #(.PW(PW), .MAXON(MAXON), .BLANK(BLANK), .MINON(MINON)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (run_en_i),
    .trip_i  (trip_i),
    .phase_i (phase),
    .wrap_i  (wrap),
    .gate_o  (gate_o),
    .start_o (cyc_start_o),
    .off_o   (off_o),
    .blank_o (blank_o)
  );

  assert_quiet_in_reset_R9: assert property (@(posedge clk)
    $past(!rst_n) |-> (!gate_o && !cyc_start_o && !off_o));

endmodule

// File: tb/jitter_pwm_timer_tb.sv
module jitter_pwm_timer_tb;
  localparam int NOM = 434, DEV = 30, MAXON = 303, BLANK = 15, MINON = 24;
  localparam int N_CYC = 140;

  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, trip = 1'b0;
  logic gate, start, offs, blank;

  always #10 clk = ~clk;

  jitter_pwm_timer #(.FAST_VARIANT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en_i(run_en), .trip_i(trip),
    .gate_o(gate), .cyc_start_o(start), .off_o(offs), .blank_o(blank)
  );

  typedef struct { int per; int on; string req; } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  int m_ofs = 0, m_dir = 1;
  bit drv_done = 1'b0;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Triangle sweep from R1: start at nominal, rise, turn at +DEV and -DEV.
  function automatic int model_next();
    int p;
    p = NOM + m_ofs;
    if (m_dir > 0) begin
      if (m_ofs >= DEV) begin m_dir = -1; m_ofs--; end else m_ofs++;
    end else begin
      if (m_ofs <= -DEV) begin m_dir = 1; m_ofs++; end else m_ofs--;
    end
    return p;
  endfunction

  // Expected on-time for a single trip at phase t (t < 0: no trip).
  function automatic int on_for_trip(int t);
    if (t < BLANK) return MAXON;        // R2 / R3
    if (t < MINON - 1) return MINON;    // R4
    if (t < MAXON) return t + 1;        // R5
    return MAXON;
  endfunction

  task automatic wait_start();
    do @(negedge clk); while (!start);
  endtask

  initial begin : driver
    int gap;
    repeat (4) begin
      @(negedge clk);
      check("R9 gate in reset", gate, 0);
      check("R9 start in reset", start, 0);
      check("R9 off in reset", offs, 0);
      check("R9 blank in reset", blank, 0);
    end
    #2 rst_n = 1'b1; run_en = 1'b1;
    gap = 0;
    do begin @(negedge clk); gap++; end while (!start);
    check("R1 first start after reset", gap, NOM);
    for (int k = 0; k < N_CYC; k++) begin
      exp_t e;
      int t;
      if (k > 0) wait_start();
      if (k == 60 || k == 100) begin
        e.req = "R6";
        e.on  = 41;
        e.per = (k == 60) ? model_next() : model_next() + model_next();
        q.push_back(e);
        repeat (40) @(negedge clk);
        #2 run_en = 1'b0;
        #1 check("R6 gate cut at once", gate, 0);
        repeat ((k == 60) ? 100 : 450) @(negedge clk);
        #2 run_en = 1'b1;
        #1 check("R6 no mid-period restart", gate, 0);
      end else if (k % 8 == 7) begin
        e.req = "R4 held trip"; e.on = MINON; e.per = model_next();
        q.push_back(e);
        #2 trip = 1'b1;
        repeat (40) @(negedge clk);
        #2 trip = 1'b0;
      end else begin
        case (k % 8)
          0: t = -1;
          1: t = 5;
          2: t = BLANK - 1;
          3: t = BLANK;
          4: t = MINON - 1;
          5: t = 100;
          default: t = MAXON - 1;
        endcase
        e.req = (t < 0) ? "R2" : (t < BLANK) ? "R3" : (t < MINON - 1) ? "R4" : "R5";
        e.on  = on_for_trip(t);
        e.per = model_next();
        q.push_back(e);
        if (t >= 0) begin
          repeat (t) @(negedge clk);
          #2 trip = 1'b1;
          @(negedge clk);
          #2 trip = 1'b0;
        end
      end
    end
    wait_start();
    @(negedge clk);
    drv_done = 1'b1;
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : monitor
    int per, on, bl;
    bit have, pg;
    exp_t e;
    have = 0; pg = 0; per = 0; on = 0; bl = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (drv_done) break;
      if (offs || (pg && !gate)) check("R8 off strobe", int'(offs), int'(pg && !gate));
      if (start || (gate && !pg)) check("R7 start strobe", int'(start), int'(gate && !pg));
      if (start) begin
        if (have) begin
          if (q.size() == 0) begin
            check("R1 scoreboard empty", 0, 1);
          end else begin
            e = q.pop_front();
            check("R1 period", per, e.per);
            check({e.req, " on-time"}, on, e.on);
            check("R3 blank length", bl, (e.on < BLANK) ? e.on : BLANK);
          end
        end
        have = 1; per = 0; on = 0; bl = 0;
      end
      per++;
      on += int'(gate);
      bl += int'(blank);
      pg = gate;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion (R1)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule